// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for the two-wire station management bus found between Ethernet MACs and PHYs. Software sets a clock divider and a frame format in a configuration word. It then starts transactions by writing a control, data or address word. The block generates the management clock from the system clock. It shifts a frame out on a bidirectional data line, which it presents as separate output, output-enable and input signals. It releases the line for the turnaround and the returned data of a read.

Two frame formats are available. The short format uses start code 01 and carries a PHY address and a register number. The extended format uses start code 00 and carries a PHY address and a device address; in this format the register address travels in a separate address frame. A busy flag covers every frame in progress. A read-error flag records a read that the PHY did not answer. An optional 32-bit all-ones preamble comes before each frame.

Top module: `mdio_master`

## Requirements
- R1: After reset the configuration word reads 0x0000_0280 (divider 5, short format, preamble on, not busy, no error), every other register reads zero, the clock is low and the output enable is low.
- R2: Word offsets are fixed: configuration at 0x30 (bit 0 busy, bit 1 read error, bit 5 preamble off, bit 6 extended format, bits 15:7 divider N), control at 0x34 (bits 4:0 register or device number, bits 9:5 PHY address, bit 15 read strobe, which reads back as 0), data at 0x38 and address at 0x3C (bits 15:0 each). Offsets 0x00 to 0x2C read zero.
- R3: While a frame runs, each clock period lasts 2*(N+1) system cycles: low for the first N+1 cycles and high for the next N+1. When no frame runs, the clock stays low.
- R4: Writing the data word in the short format sends, MSB first, 32 ones, then 01, 01, the PHY address, the register number, turnaround 10 and the 16 data bits. The first bit is driven in the cycle the write is taken, and each later bit changes only on a falling clock edge.
- R5: A control write with bit 15 set in the short format sends 01, 10, PHY address and register number. The output enable goes low for the two turnaround bits and the 16 data bits. The 16 bits sampled on rising clock edges land in the data word, MSB first.
- R6: In the extended format, writing the address word sends an address frame 00, 00, PHY address, device address, 10, value. In the short format, an address write only stores the value.
- R7: In the extended format, a data write sends opcode 01 and a read sends opcode 11, both with start code 00.
- R8: If the line reads 1 at the second turnaround bit of a read, then the error bit is set and the data word becomes 0xFFFF when the frame ends. The error bit clears when the next read starts.
- R9: With the preamble-off bit set, a frame holds only its 32 frame bits.
- R10: Busy reads 1 from the cycle a frame is taken until the falling edge that ends its last bit. That is exactly bits*2*(N+1) cycles.
- R11: Every register write made while busy is ignored.
- R12: When no frame runs, the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
A wrong bit index or opcode shows on the pin as a wrong bit, or as an enable that drops too early or too late, at the falling edge that starts that bit. A broken divider count moves the very first rising edge, which comes N+1 cycles after launch. A faulty capture or error decision shows only when the frame ends, in the data word and the error bit. A busy flag that fails to block writes shows in the configuration or data word after the frame. The bench therefore compares the pins and the configuration word in every cycle, and it reads the data word after every read.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam logic [1:0] ST_SHORT = 2'b01;
   localparam logic [1:0] ST_EXT   = 2'b00;
   localparam logic [1:0] OP_ADDR  = 2'b00;
   localparam logic [1:0] OP_WR    = 2'b01;
   localparam logic [1:0] OP_RD_S  = 2'b10;
   localparam logic [1:0] OP_RD_E  = 2'b11;
   localparam int         FRAME_BITS = 32;

   typedef struct packed {
      logic [1:0]  st;
      logic [1:0]  op;
      logic [4:0]  pa;
      logic [4:0]  da;
      logic [15:0] payload;
      logic        rd;
   } mdio_req_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int DIV_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise_p,
   output logic             fall_p
);
   logic [DIV_W-1:0] cnt_q;
   logic             mdc_q;
   logic             tick;

   assign tick   = run && (cnt_q == div);
   assign rise_p = tick && !mdc_q;
   assign fall_p = tick && mdc_q;
   assign mdc    = mdc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (tick) begin
         cnt_q <= '0;
         mdc_q <= ~mdc_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32,
   parameter bit IN_FLOP = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  mdio_req_t req,
   input  logic      pre_off,
   input  logic      rise_p,
   input  logic      fall_p,
   input  logic      mdio_i,
   output logic      busy,
   output logic      mdio_o,
   output logic      mdio_oe,
   output logic      done,
   output logic [15:0] rd_word,
   output logic      rd_fail
);
   localparam int TOT   = PRE_LEN + FRAME_BITS;
   localparam int IDX_W = $clog2(TOT);
   localparam logic [IDX_W-1:0] LAST  = IDX_W'(TOT - 1);
   localparam logic [IDX_W-1:0] FIRST = IDX_W'(PRE_LEN);

   logic                  busy_q, is_rd_q, ta_q;
   logic [IDX_W-1:0]      idx_q;
   logic [FRAME_BITS-1:0] frm_q;
   logic [15:0]           sh_q;
   logic                  din;
   logic                  in_frame;
   logic [IDX_W-1:0]      fpos;
   logic [4:0]            bsel;

   generate
      if (IN_FLOP) begin : g_in_reg
         logic din_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) din_q <= 1'b1;
            else        din_q <= mdio_i;
         end
         assign din = din_q;
      end else begin : g_in_direct
         assign din = mdio_i;
      end
   endgenerate

   assign in_frame = (idx_q >= FIRST);
   assign fpos     = idx_q - FIRST;
   assign bsel     = 5'(FRAME_BITS - 1) - fpos[4:0];

   assign busy    = busy_q;
   assign mdio_o  = busy_q && (in_frame ? frm_q[bsel] : 1'b1);
   assign mdio_oe = busy_q && !(is_rd_q && in_frame && (fpos >= IDX_W'(14)));
   assign done    = busy_q && fall_p && (idx_q == LAST);
   assign rd_fail = ta_q;
   assign rd_word = ta_q ? 16'hFFFF : sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         is_rd_q <= 1'b0;
         ta_q    <= 1'b0;
         idx_q   <= '0;
         frm_q   <= '0;
         sh_q    <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q  <= 1'b1;
            is_rd_q <= req.rd;
            ta_q    <= 1'b0;
            idx_q   <= pre_off ? FIRST : '0;
            frm_q   <= {req.st, req.op, req.pa, req.da,
                        (req.rd ? 2'b11 : 2'b10), req.payload};
         end
      end else begin
         if (rise_p && is_rd_q && in_frame) begin
            if (fpos == IDX_W'(15)) ta_q <= din;
            if (fpos >= IDX_W'(16)) sh_q <= {sh_q[14:0], din};
         end
         if (fall_p) begin
            if (idx_q == LAST) busy_q <= 1'b0;
            else               idx_q  <= idx_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int DIV_W     = 9,
   parameter int DIV_RESET = 5,
   parameter int PRE_LEN   = 32,
   parameter bit IN_FLOP   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'(8'h30);
   localparam logic [ADDR_W-1:0] OFS_CTL  = ADDR_W'(8'h34);
   localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(8'h38);
   localparam logic [ADDR_W-1:0] OFS_ADR  = ADDR_W'(8'h3C);

   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must cover offset 0x3C");
   end
   if (DIV_W < 3 || DIV_W > 9) begin : g_bad_div_w
      $error("DIV_W must be 3..9");
   end
   if (DIV_RESET < 5 || DIV_RESET >= (1 << DIV_W)) begin : g_bad_div_rst
      $error("DIV_RESET out of range");
   end
   if (PRE_LEN < 1 || PRE_LEN > 32) begin : g_bad_pre
      $error("PRE_LEN must be 1..32");
   end

   logic [DIV_W-1:0] div_q;
   logic             ext_q, pre_off_q, rd_err_q, rd_pend_q;
   logic [9:0]       ctl_q;
   logic [15:0]      data_q, adr_q;
   logic             busy, done, rd_fail, rise_p, fall_p, launch, accept;
   logic [15:0]      rd_word;
   mdio_req_t        req;

   assign accept = reg_we && !busy;

   always_comb begin
      launch      = 1'b0;
      req.st      = ext_q ? ST_EXT : ST_SHORT;
      req.op      = OP_WR;
      req.pa      = ctl_q[9:5];
      req.da      = ctl_q[4:0];
      req.payload = reg_wdata[15:0];
      req.rd      = 1'b0;
      if (accept) begin
         if (reg_addr == OFS_CTL && reg_wdata[15]) begin
            launch      = 1'b1;
            req.op      = ext_q ? OP_RD_E : OP_RD_S;
            req.pa      = reg_wdata[9:5];
            req.da      = reg_wdata[4:0];
            req.payload = '0;
            req.rd      = 1'b1;
         end else if (reg_addr == OFS_DATA) begin
            launch = 1'b1;
         end else if (reg_addr == OFS_ADR && ext_q) begin
            launch = 1'b1;
            req.op = OP_ADDR;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q     <= DIV_W'(DIV_RESET);
         ext_q     <= 1'b0;
         pre_off_q <= 1'b0;
         rd_err_q  <= 1'b0;
         rd_pend_q <= 1'b0;
         ctl_q     <= '0;
         data_q    <= '0;
         adr_q     <= '0;
      end else begin
         if (accept) begin
            case (reg_addr)
               OFS_CFG: begin
                  div_q     <= reg_wdata[7 +: DIV_W];
                  ext_q     <= reg_wdata[6];
                  pre_off_q <= reg_wdata[5];
               end
               OFS_CTL:  ctl_q  <= reg_wdata[9:0];
               OFS_DATA: data_q <= reg_wdata[15:0];
               OFS_ADR:  adr_q  <= reg_wdata[15:0];
               default: ;
            endcase
         end
         if (launch) begin
            rd_pend_q <= req.rd;
            if (req.rd) rd_err_q <= 1'b0;
         end
         if (done && rd_pend_q) begin
            data_q   <= rd_word;
            rd_err_q <= rd_fail;
         end
      end
   end

   always_comb begin
      case (reg_addr)
         OFS_CFG:  reg_rdata = {16'h0, 9'(div_q), ext_q, pre_off_q, 3'b000, rd_err_q, busy};
         OFS_CTL:  reg_rdata = {22'h0, ctl_q};
         OFS_DATA: reg_rdata = {16'h0, data_q};
         OFS_ADR:  reg_rdata = {16'h0, adr_q};
         default:  reg_rdata = '0;
      endcase
   end

   mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (busy),
      .div    (div_q),
      .mdc    (mdc),
      .rise_p (rise_p),
      .fall_p (fall_p)
   );

   mdio_frame #(.PRE_LEN(PRE_LEN), .IN_FLOP(IN_FLOP)) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (launch),
      .req     (req),
      .pre_off (pre_off_q),
      .rise_p  (rise_p),
      .fall_p  (fall_p),
      .mdio_i  (mdio_i),
      .busy    (busy),
      .mdio_o  (mdio_o),
      .mdio_oe (mdio_oe),
      .done    (done),
      .rd_word (rd_word),
      .rd_fail (rd_fail)
   );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
   parameter int DIV_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             mdc,
   input logic             mdio_o,
   input logic             mdio_oe,
   input logic             rd_err,
   input logic             reg_we,
   input logic [DIV_W-1:0] div
);
   // R12 and R3: idle bus is released with the clock parked low
   a_r12_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdio_oe && !mdc));

   // R4: line value and enable move only while the clock is low
   a_r4_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

   // R3: a rising clock only inside a frame
   a_r3_mdc_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> busy);

   // R11: configuration untouched by writes during a frame
   a_r11_busy_writes_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_we) |=> $stable(div));

   // R8: the error flag appears only as a frame ends
   a_r8_err_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_err) |-> $fell(busy));
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .mdc     (mdc),
   .mdio_o  (mdio_o),
   .mdio_oe (mdio_oe),
   .rd_err  (rd_err_q),
   .reg_we  (reg_we),
   .div     (div_q)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [5:0]  reg_addr = 6'h30;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   always #10 clk = ~clk; // 20 time-unit period, 50 MHz nominal

   mdio_master u_mdio_master (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   int total = 0;
   int bad   = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   localparam logic [4:0] PHY_ADDR = 5'd3;
   logic        phy_present = 1'b1;
   logic [15:0] phy_val = 16'h0;

   logic [8:0]  m_div = 9'd5;
   logic        m_ext = 0, m_pre = 0, m_err = 0, m_act = 0, m_rd = 0, m_ok = 0;
   logic [9:0]  m_ctl = '0;
   logic [15:0] m_data = '0, m_adr = '0;
   int          m_k = 0, m_h = 6, m_pl = 32;
   bit          m_o[$];
   bit          m_oe[$];

   function automatic void m_start(input logic [1:0] op, input logic [15:0] pay, input bit rd);
      logic [31:0] fv;
      fv = {(m_ext ? 2'b00 : 2'b01), op, m_ctl[9:5], m_ctl[4:0],
            (rd ? 2'b11 : 2'b10), (rd ? 16'h0 : pay)};
      m_o.delete(); m_oe.delete();
      m_pl = m_pre ? 0 : 32;
      for (int i = 0; i < m_pl; i++) begin m_o.push_back(1'b1); m_oe.push_back(1'b1); end
      for (int i = 0; i < 32; i++) begin
         m_o.push_back(fv[31-i]);
         m_oe.push_back(!(rd && i >= 14));
      end
      m_rd = rd; m_ok = phy_present && (m_ctl[9:5] == PHY_ADDR);
      if (rd) m_err = 1'b0;
      m_h = int'(m_div) + 1; m_k = 0; m_act = 1'b1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_div = 9'd5; m_ext = 0; m_pre = 0; m_err = 0; m_act = 0;
         m_ctl = '0; m_data = '0; m_adr = '0;
      end else if (m_act) begin
         m_k++;
         if (m_k == m_o.size() * 2 * m_h) begin
            m_act = 1'b0;
            if (m_rd) begin
               m_data = m_ok ? phy_val : 16'hFFFF;
               m_err  = !m_ok;
            end
         end
      end else if (reg_we) begin
         case (reg_addr)
            6'h30: begin m_div = reg_wdata[15:7]; m_ext = reg_wdata[6]; m_pre = reg_wdata[5]; end
            6'h34: begin
               m_ctl = reg_wdata[9:0];
               if (reg_wdata[15]) m_start(m_ext ? 2'b11 : 2'b10, 16'h0, 1'b1);
            end
            6'h38: begin m_data = reg_wdata[15:0]; m_start(2'b01, reg_wdata[15:0], 1'b0); end
            6'h3C: begin m_adr = reg_wdata[15:0]; if (m_ext) m_start(2'b00, reg_wdata[15:0], 1'b0); end
            default: ;
         endcase
      end
   end

   // per-cycle comparison and PHY response, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         int b, f;
         logic e_mdc, e_oe;
         b = m_k / (2 * m_h);
         e_mdc = m_act && ((m_k % (2 * m_h)) >= m_h);
         e_oe  = m_act && m_oe[b];
         chk("R3 mdc", {31'h0, mdc}, {31'h0, e_mdc});
         chk("R12 mdio_oe", {31'h0, mdio_oe}, {31'h0, e_oe});
         if (e_oe) chk("R4 mdio_o bit", {31'h0, mdio_o}, {31'h0, m_o[b]});
         if (reg_addr == 6'h30 && !reg_we)
            chk("R10 config word", reg_rdata,
                {16'h0, m_div, m_ext, m_pre, 3'b000, m_err, m_act});
         mdio_i = 1'b1;
         if (m_act && m_rd) begin
            f = b - m_pl;
            if (f == 15 && m_ok) mdio_i = 1'b0;
            if (f >= 16 && m_ok) mdio_i = phy_val[31-f];
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_addr = 6'h30;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
      reg_addr = 6'h30;
   endtask

   task automatic wait_idle();
      while (m_act) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      logic [31:0] v;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      rd(6'h30, v); chk("R1 cfg reset", v, 32'h280);
      rd(6'h34, v); chk("R1 ctl reset", v, 0);
      rd(6'h38, v); chk("R1 data reset", v, 0);
      rd(6'h3C, v); chk("R1 addr reset", v, 0);
      chk("R1 pins idle", {30'h0, mdc, mdio_oe}, 0);
      // R2 reserved space
      rd(6'h00, v); chk("R2 reserved 0x00", v, 0);
      rd(6'h2C, v); chk("R2 reserved 0x2C", v, 0);
      // short format write
      wr(6'h34, 32'h0000_0062);
      rd(6'h34, v); chk("R2 ctl readback", v, 32'h62);
      wr(6'h38, 32'h0000_A5C3);
      wait_idle();
      rd(6'h38, v); chk("R4 data after write", v, 32'hA5C3);
      // short format read
      phy_val = 16'h1234;
      wr(6'h34, 32'h0000_8062);
      wait_idle();
      rd(6'h38, v); chk("R5 read data", v, 32'h1234);
      rd(6'h34, v); chk("R2 read strobe reads 0", v, 32'h62);
      // address write in short format: no frame
      wr(6'h3C, 32'h0000_0055);
      repeat (4) @(negedge clk);
      rd(6'h30, v); chk("R6 no frame in short format", {31'h0, v[0]}, 0);
      rd(6'h3C, v); chk("R6 addr stored", v, 32'h55);
      // extended format, divider 7, preamble off
      wr(6'h30, 32'h0000_03E0);
      rd(6'h30, v); chk("R9 cfg", v, 32'h3E0);
      wr(6'h34, 32'h0000_0061);
      wr(6'h3C, 32'h0000_BEEF);
      wait_idle();
      wr(6'h38, 32'h0000_1357);
      n = 0;
      while (reg_rdata[0]) begin n++; @(negedge clk); end
      chk("R10 busy length", n, 32 * 2 * 8);
      wait_idle();
      phy_val = 16'h2468;
      wr(6'h34, 32'h0000_8061);
      wait_idle();
      rd(6'h38, v); chk("R7 extended read", v, 32'h2468);
      // R11 writes while busy
      wr(6'h38, 32'h0000_1111);
      wr(6'h38, 32'h0000_FFFF);
      wr(6'h30, 32'h0000_0000);
      wait_idle();
      rd(6'h38, v); chk("R11 data kept", v, 32'h1111);
      rd(6'h30, v); chk("R11 cfg kept", v, 32'h3E0);
      // R8 missing PHY
      wr(6'h34, 32'h0000_8121);
      wait_idle();
      rd(6'h38, v); chk("R8 data all ones", v, 32'hFFFF);
      rd(6'h30, v); chk("R8 error set", {31'h0, v[1]}, 1);
      wr(6'h34, 32'h0000_8061);
      rd(6'h30, v); chk("R8 error cleared at launch", {31'h0, v[1]}, 0);
      wait_idle();
      rd(6'h38, v); chk("R8 good read after error", v, 32'h2468);
      // preamble back on, extended write at divider 5
      wr(6'h30, 32'h0000_02C0);
      wr(6'h38, 32'h0000_0F0F);
      n = 0;
      while (reg_rdata[0]) begin n++; @(negedge clk); end
      chk("R9 busy with preamble", n, 64 * 2 * 6);
      wait_idle();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule